// File: doc/BRIEF.md
# Conditional Flow Control Unit

This unit resolves the conditional control-transfer instructions of a small 16-bit DSP core: jump, call, return and return-from-exception, each qualified by a 4-bit condition code. It holds the program counter and the status register. Each clock it accepts at most one decoded instruction word, plus the optional second word of a two-word instruction. In the same cycle it presents the next program counter, and it registers that value on the following edge.

Return addresses live on a hardware call stack. Saved status words live on a separate status stack. A conditional return-from-exception restores the status word from the status stack and the program counter from the call stack, and both stacks are popped. When its condition fails, the instruction only advances the PC. A test hook pushes the current PC and status word the way exception entry would. The ALU side loads new flags through a write strobe.

Top module: `cond_flow_unit`

## Requirements
- R1: A valid word whose bits [15:8] equal 0x02 is decoded by bits [7:4]: 1001 conditional jump, 1011 conditional call, 1101 conditional return, 1111 conditional return-from-exception. Bits [3:0] hold the condition code. Any other valid word advances the PC by 1.
- R2: `pc_out` equals the `pc_next` value of the previous cycle. With `instr_valid` low, `pc_next` equals `pc_out`.
- R3: The condition codes read status bits C=bit0, V=bit1, Z=bit2, S=bit3. The codes are: 0 S==V, 1 S!=V, 2 !Z&&S==V, 3 Z||S!=V, 4 !Z, 5 Z, 6 !C, 7 C, 8 !S, 9 S, 10 !V, 11 V, 12 Z||C, 13 !(Z||C), 14 never, 15 always.
- R4: A taken jump loads the second word into the PC. A jump that is not taken gives PC+2, modulo 2^16.
- R5: A taken call pushes PC+2 onto the call stack and loads the second word into the PC. A call that is not taken gives PC+2 and pushes nothing.
- R6: A taken return pops the call stack into the PC. A return that is not taken gives PC+1.
- R7: A taken return-from-exception loads the status register from the status stack and the PC from the call stack, and pops both. This restore wins over an ALU status write in the same cycle.
- R8: A return-from-exception that is not taken gives PC+1 and leaves the status register and both stacks unchanged.
- R9: Each stack holds 4 entries. A push onto a full stack is dropped and sets that stack's overflow flag. A pop from an empty stack returns 0 and sets that stack's underflow flag. The flags clear only on reset.
- R10: `exc_push` pushes `pc_out` onto the call stack and `sr_out` onto the status stack. An instruction presented in the same cycle is ignored and the PC holds.
- R11: When no restore happens, `alu_sr_we` loads `alu_sr` into the status register on the next edge.
- R12: Reset clears the PC, the status register, both stack depths and all four error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | An instruction is presented this cycle |
| instr_word | input | 16 | First instruction word |
| instr_ext | input | 16 | Second word (absolute target) |
| alu_sr_we | input | 1 | Load status register from ALU |
| alu_sr | input | 16 | New status word from ALU |
| exc_push | input | 1 | Test hook: push PC and status as exception entry |
| pc_next | output | 16 | Next program counter (combinational) |
| pc_out | output | 16 | Registered program counter |
| sr_out | output | 16 | Registered status register |
| cs_ovf | output | 1 | Call stack overflow (sticky) |
| cs_unf | output | 1 | Call stack underflow (sticky) |
| ss_ovf | output | 1 | Status stack overflow (sticky) |
| ss_unf | output | 1 | Status stack underflow (sticky) |

## Verification
The bench builds the unit with its defaults: 16-bit words and a stack depth of 4. With a depth of 4, a fifth call or hook push overflows a stack, and runs of returns drain a stack into underflow within a few cycles, so the random mix reaches both sticky flags often. The 16-bit address width lets jumps to 0xFFFE and 0xFFFF exercise the PC+1 and PC+2 wraparound. With only four status bits feeding the 16 condition codes, every code can be swept against every flag combination.

// File: rtl/cfu_pkg.sv
package cfu_pkg;
  typedef enum logic [2:0] {
    OP_NONE, OP_SEQ, OP_JMP, OP_CALL, OP_RET, OP_RTI
  } cf_op_e;

  localparam int SR_C = 0;
  localparam int SR_V = 1;
  localparam int SR_Z = 2;
  localparam int SR_S = 3;

  localparam logic [7:0] GRP_FLOW = 8'h02;

  typedef struct packed {
    cf_op_e     op;
    logic [3:0] cc;
  } cf_dec_t;
endpackage

// File: rtl/cfu_decode.sv
module cfu_decode
  import cfu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         valid,
  input  logic [W-1:0] word,
  output cf_dec_t      dec
);
  logic in_grp;
  assign in_grp = (word[15:8] == GRP_FLOW);

  always_comb begin
    dec.cc = word[3:0];
    dec.op = OP_NONE;
    if (valid) begin
      dec.op = OP_SEQ;
      if (in_grp) begin
        case (word[7:4])
          4'b1001: dec.op = OP_JMP;
          4'b1011: dec.op = OP_CALL;
          4'b1101: dec.op = OP_RET;
          4'b1111: dec.op = OP_RTI;
          default: dec.op = OP_SEQ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfu_cond.sv
module cfu_cond
  import cfu_pkg::*;
#(
  parameter int SR_W = 16
) (
  input  logic [3:0]      cc,
  input  logic [SR_W-1:0] sr,
  output logic            ok
);
  logic fz, fc, fs, fv, lt;
  assign fz = sr[SR_Z];
  assign fc = sr[SR_C];
  assign fs = sr[SR_S];
  assign fv = sr[SR_V];
  assign lt = fs ^ fv;

  always_comb begin
    unique case (cc)
      4'd0:  ok = !lt;
      4'd1:  ok = lt;
      4'd2:  ok = !fz && !lt;
      4'd3:  ok = fz || lt;
      4'd4:  ok = !fz;
      4'd5:  ok = fz;
      4'd6:  ok = !fc;
      4'd7:  ok = fc;
      4'd8:  ok = !fs;
      4'd9:  ok = fs;
      4'd10: ok = !fv;
      4'd11: ok = fv;
      4'd12: ok = fz || fc;
      4'd13: ok = !(fz || fc);
      4'd14: ok = 1'b0;
      default: ok = 1'b1;
    endcase
  end
endmodule

// File: rtl/cfu_lifo.sv
module cfu_lifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] top,
  output logic         empty,
  output logic         full,
  output logic         ovf,
  output logic         unf
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] cnt;
  logic [AW-1:0] wr_idx, rd_idx;

  assign empty  = (cnt == '0);
  assign full   = (cnt == CW'(DEPTH));
  assign wr_idx = AW'(cnt);
  assign rd_idx = AW'(cnt - CW'(1));
  assign top    = empty ? '0 : mem[rd_idx];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      ovf <= 1'b0;
      unf <= 1'b0;
    end else begin
      if (push && !full)      cnt <= cnt + CW'(1);
      else if (pop && !empty) cnt <= cnt - CW'(1);
      if (push && full)  ovf <= 1'b1;
      if (pop && empty)  unf <= 1'b1;
    end
  end

  a_r9_no_push_pop: assert property (@(posedge clk) disable iff (rst) !(push && pop));
  a_r9_ovf_sticky:  assert property (@(posedge clk) disable iff (rst) ovf |=> ovf);
  a_r9_unf_sticky:  assert property (@(posedge clk) disable iff (rst) unf |=> unf);
  a_r9_full_push:   assert property (@(posedge clk) disable iff (rst)
                      (full && push) |=> (full && ovf));
  a_r9_empty_pop:   assert property (@(posedge clk) disable iff (rst)
                      (empty && pop) |=> (empty && unf));
  always_comb begin
    if (!rst) a_r9_count_bound: assert (cnt <= CW'(DEPTH));
  end
endmodule

// File: rtl/cond_flow_unit.sv
module cond_flow_unit
  import cfu_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int STACK_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic [DATA_W-1:0] instr_word,
  input  logic [ADDR_W-1:0] instr_ext,
  input  logic              alu_sr_we,
  input  logic [DATA_W-1:0] alu_sr,
  input  logic              exc_push,
  output logic [ADDR_W-1:0] pc_next,
  output logic [ADDR_W-1:0] pc_out,
  output logic [DATA_W-1:0] sr_out,
  output logic              cs_ovf,
  output logic              cs_unf,
  output logic              ss_ovf,
  output logic              ss_unf
);
  localparam logic [ADDR_W-1:0] STEP1 = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(2);

  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] sr_q, sr_d;
  cf_dec_t           dec;
  logic              cond_ok, go;
  logic              cs_push, cs_pop, ss_push, ss_pop;
  logic [ADDR_W-1:0] cs_wdata, cs_top;
  logic [DATA_W-1:0] ss_top;
  logic              cs_empty, cs_full, ss_empty, ss_full;

  cfu_decode #(.W(DATA_W)) u_dec (
    .valid(instr_valid), .word(instr_word), .dec(dec)
  );

  cfu_cond #(.SR_W(DATA_W)) u_cond (
    .cc(dec.cc), .sr(sr_q), .ok(cond_ok)
  );

  assign go       = !exc_push && cond_ok;
  assign cs_push  = exc_push || (go && dec.op == OP_CALL);
  assign cs_wdata = exc_push ? pc_q : pc_q + STEP2;
  assign cs_pop   = go && (dec.op == OP_RET || dec.op == OP_RTI);
  assign ss_push  = exc_push;
  assign ss_pop   = go && dec.op == OP_RTI;

  cfu_lifo #(.W(ADDR_W), .DEPTH(STACK_DEPTH)) u_call_stk (
    .clk(clk), .rst(rst), .push(cs_push), .pop(cs_pop), .wdata(cs_wdata),
    .top(cs_top), .empty(cs_empty), .full(cs_full), .ovf(cs_ovf), .unf(cs_unf)
  );

  cfu_lifo #(.W(DATA_W), .DEPTH(STACK_DEPTH)) u_stat_stk (
    .clk(clk), .rst(rst), .push(ss_push), .pop(ss_pop), .wdata(sr_q),
    .top(ss_top), .empty(ss_empty), .full(ss_full), .ovf(ss_ovf), .unf(ss_unf)
  );

  always_comb begin
    pc_next = pc_q;
    if (!exc_push) begin
      unique case (dec.op)
        OP_NONE:          pc_next = pc_q;
        OP_JMP, OP_CALL:  pc_next = cond_ok ? instr_ext : pc_q + STEP2;
        OP_RET, OP_RTI:   pc_next = cond_ok ? cs_top : pc_q + STEP1;
        default:          pc_next = pc_q + STEP1;
      endcase
    end
  end

  always_comb begin
    if (ss_pop)         sr_d = ss_top;
    else if (alu_sr_we) sr_d = alu_sr;
    else                sr_d = sr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
      sr_q <= '0;
    end else begin
      pc_q <= pc_next;
      sr_q <= sr_d;
    end
  end

  assign pc_out = pc_q;
  assign sr_out = sr_q;

  logic chk_armed;
  always_ff @(posedge clk) chk_armed <= !rst;

  a_r2_pc_registered: assert property (@(posedge clk) disable iff (rst)
    chk_armed |-> (pc_q == $past(pc_next)));
  a_r8_rti_skip_keeps_sr: assert property (@(posedge clk) disable iff (rst)
    (dec.op == OP_RTI && !cond_ok && !exc_push && !alu_sr_we) |=> (sr_q == $past(sr_q)));
  a_r7_rti_restores_sr: assert property (@(posedge clk) disable iff (rst)
    (dec.op == OP_RTI && cond_ok && !exc_push && !ss_empty) |=> (sr_q == $past(ss_top)));
  a_r5_call_link: assert property (@(posedge clk) disable iff (rst)
    (dec.op == OP_CALL && cond_ok && !exc_push && !cs_full) |=>
    (cs_top == $past(pc_q) + STEP2));
  a_r10_hook_holds_pc: assert property (@(posedge clk) disable iff (rst)
    exc_push |=> (pc_q == $past(pc_q)));
  a_r10_hook_saves_sr: assert property (@(posedge clk) disable iff (rst)
    (exc_push && !ss_full) |=> (ss_top == $past(sr_q)));
endmodule

// File: tb/test_cond_flow_unit.sv
module test_cond_flow_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        v = 1'b0, exc = 1'b0, awe = 1'b0;
  logic [15:0] w = '0, x = '0, asr = '0;
  logic [15:0] pc_next, pc_out, sr_out;
  logic        cs_ovf, cs_unf, ss_ovf, ss_unf;

  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  cond_flow_unit i_cond_flow_unit (
    .clk(clk), .rst(rst), .instr_valid(v), .instr_word(w), .instr_ext(x),
    .alu_sr_we(awe), .alu_sr(asr), .exc_push(exc), .pc_next(pc_next),
    .pc_out(pc_out), .sr_out(sr_out), .cs_ovf(cs_ovf), .cs_unf(cs_unf),
    .ss_ovf(ss_ovf), .ss_unf(ss_unf)
  );

  // reference state
  logic [15:0] m_pc, m_sr;
  logic [15:0] m_cs [4];
  logic [15:0] m_ss [4];
  int          m_csn, m_ssn;
  logic [3:0]  m_flags; // {cs_ovf, cs_unf, ss_ovf, ss_unf}
  logic [15:0] e_pnext;
  string       tag;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic cond(logic [3:0] cc, logic [15:0] sr);
    logic c = sr[0], o = sr[1], z = sr[2], s = sr[3];
    case (cc)
      4'd0: return s == o;
      4'd1: return s != o;
      4'd2: return !z && (s == o);
      4'd3: return z || (s != o);
      4'd4: return !z;
      4'd5: return z;
      4'd6: return !c;
      4'd7: return c;
      4'd8: return !s;
      4'd9: return s;
      4'd10: return !o;
      4'd11: return o;
      4'd12: return z || c;
      4'd13: return !(z || c);
      4'd14: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic cs_push(logic [15:0] d);
    if (m_csn == 4) m_flags[3] = 1'b1; else begin m_cs[m_csn] = d; m_csn++; end
  endtask
  task automatic ss_push(logic [15:0] d);
    if (m_ssn == 4) m_flags[1] = 1'b1; else begin m_ss[m_ssn] = d; m_ssn++; end
  endtask
  function automatic logic [15:0] cs_pop();
    if (m_csn == 0) begin m_flags[2] = 1'b1; return 16'h0; end
    m_csn--; return m_cs[m_csn];
  endfunction
  function automatic logic [15:0] ss_pop();
    if (m_ssn == 0) begin m_flags[0] = 1'b1; return 16'h0; end
    m_ssn--; return m_ss[m_ssn];
  endfunction

  task automatic model();
    logic       c;
    logic       restored = 1'b0;
    logic [15:0] nsr = m_sr;
    e_pnext = m_pc;
    tag = "R2";
    if (exc) begin
      tag = "R10";
      cs_push(m_pc);
      ss_push(m_sr);
    end else if (v) begin
      c = cond(w[3:0], m_sr);
      tag = "R1";
      e_pnext = m_pc + 16'd1;
      if (w[15:8] == 8'h02) begin
        case (w[7:4])
          4'b1001: begin tag = "R4"; e_pnext = c ? x : m_pc + 16'd2; end
          4'b1011: begin
            tag = "R5";
            e_pnext = c ? x : m_pc + 16'd2;
            if (c) cs_push(m_pc + 16'd2);
          end
          4'b1101: begin tag = "R6"; if (c) e_pnext = cs_pop(); end
          4'b1111: begin
            tag = c ? "R7" : "R8";
            if (c) begin nsr = ss_pop(); e_pnext = cs_pop(); restored = 1'b1; end
          end
          default: ;
        endcase
      end
    end
    if (!restored && awe) nsr = asr;
    m_pc = e_pnext;
    m_sr = nsr;
  endtask

  task automatic step(logic iv, logic [15:0] iw, logic [15:0] ix,
                      logic ie, logic iawe, logic [15:0] iasr, string force_tag);
    @(negedge clk);
    v = iv; w = iw; x = ix; exc = ie; awe = iawe; asr = iasr;
    #1;
    model();
    if (force_tag != "") tag = force_tag;
    check(tag, {16'h0, pc_next}, {16'h0, e_pnext});
    @(posedge clk);
    #1;
    check((tag == "R2") ? "R2" : (awe ? "R11" : tag), {16'h0, pc_out}, {16'h0, m_pc});
    check(tag == "R7" ? "R7" : "R11", {16'h0, sr_out}, {16'h0, m_sr});
    check("R9", {28'h0, cs_ovf, cs_unf, ss_ovf, ss_unf}, {28'h0, m_flags});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; v = 0; exc = 0; awe = 0;
    repeat (2) @(posedge clk);
    #1;
    m_pc = 0; m_sr = 0; m_csn = 0; m_ssn = 0; m_flags = 0;
    check("R12", {16'h0, pc_out}, 32'h0);
    check("R12", {16'h0, sr_out}, 32'h0);
    check("R12", {28'h0, cs_ovf, cs_unf, ss_ovf, ss_unf}, 32'h0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int seed = 32'h5eed;
    void'($urandom(seed));
    do_reset();

    // R3: every code against every flag nibble, via conditional jump
    for (int s = 0; s < 16; s++) begin
      step(0, 0, 0, 0, 1, 16'(s), "R11");
      for (int cc = 0; cc < 16; cc++)
        step(1, {8'h02, 4'b1001, 4'(cc)}, 16'h1000 + 16'(cc), 0, 0, 0, "R3");
    end

    // R9 overflow on call stack and underflow on return
    for (int i = 0; i < 5; i++) step(1, 16'h02BF, 16'h0200 + 16'(i), 0, 0, 0, "R9");
    for (int i = 0; i < 5; i++) step(1, 16'h02DF, 0, 0, 0, 0, "R9");
    // R1 other opcode; R4 wraparound
    step(1, 16'h1234, 0, 0, 0, 0, "R1");
    step(1, 16'h029F, 16'hFFFF, 0, 0, 0, "R4");
    step(1, 16'h029E, 16'h0000, 0, 0, 0, "R4");
    do_reset();
    // R10 hook with instruction present, R7 restore beats ALU write
    step(0, 0, 0, 0, 1, 16'h000B, "R11");
    step(1, 16'h029F, 16'h0400, 0, 0, 0, "R4");
    step(1, 16'h029F, 16'h0777, 1, 0, 0, "R10");
    step(0, 0, 0, 0, 1, 16'h0004, "R11");
    step(1, 16'h02FE, 0, 0, 0, 0, "R8");
    step(1, 16'h02FF, 0, 0, 1, 16'h00F0, "R7");
    step(1, 16'h02FF, 0, 0, 0, 0, "R7");

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] rw;
      logic [3:0]  opn;
      if (i == 1500) do_reset();
      case ($urandom_range(0, 4))
        0: opn = 4'b1001;
        1: opn = 4'b1011;
        2: opn = 4'b1101;
        3: opn = 4'b1111;
        default: opn = 4'($urandom);
      endcase
      rw = ($urandom_range(0, 9) == 0) ? 16'($urandom)
                                       : {8'h02, opn, 4'($urandom)};
      step($urandom_range(0, 9) != 0, rw, 16'($urandom),
           $urandom_range(0, 9) == 0, $urandom_range(0, 4) == 0,
           16'($urandom_range(0, 15)), "");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule